// File: doc/BRIEF.md
# Shadowed Nonvolatile Register Controller

This block fronts a small bank of configuration locations whose lasting values sit in a slow nonvolatile array, while every access from the rest of the chip is served by a fast volatile copy. A mode input picks one of two write paths. With the mode input clear, a write changes the volatile copy and also starts a nonvolatile write. That write takes a fixed number of cycles, and the block reports busy and refuses further writes until it is done. With the mode input set, a write changes only the volatile copy. It takes effect at once, may be repeated without limit, and is forgotten at the next power cycle.

A power-on strobe, and the chip reset, make the block refill the whole volatile copy from the nonvolatile array, one location per cycle. No access is accepted during the refill. After the refill, every location again holds the last value written with the mode input clear. A behavioural nonvolatile model with a parameterised write delay is part of the design.

Top module: `snv_ctrl`

## Requirements
- R1: After reset release, and after every accepted power-on strobe, `loading` is high for exactly DEPTH (2^ADDR_W) consecutive cycles. During those cycles `wr_ready` is low and a read request produces no `rd_valid`. A strobe that arrives during a refill restarts the refill at location 0.
- R2: A write accepted with `shadow_en` = 0 raises `busy` from the next cycle for WR_DELAY+1 cycles. `wr_ready` is low for the whole time.
- R3: A write accepted with `shadow_en` = 1 raises no `busy`. `wr_ready` stays high, so a write can be accepted on every cycle.
- R4: A read request returns the volatile value of `rd_addr` on `rd_data` with `rd_valid` high in the following cycle. A read and a write to the same address in the same cycle return the value from before the write.
- R5: Read requests are served while `busy` is high.
- R6: After a power-on strobe and its refill, each location reads back the last value written to it with `shadow_en` = 0. Values written with `shadow_en` = 1 are gone. Locations never written that way read 0.
- R7: A write with `shadow_en` = 0 is visible to reads from the cycle after it is accepted, before the nonvolatile write completes.
- R8: A power-on strobe that arrives while `busy` is high is held until the nonvolatile write finishes. The refill then starts, and it returns the newly committed value.
- R9: A write request in the same cycle as a power-on strobe is not accepted: `wr_ready` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears the nonvolatile model and starts a refill |
| por_strobe | input | 1 | Power-on strobe; requests a refill from nonvolatile storage |
| shadow_en | input | 1 | 1: writes touch only the volatile copy; 0: writes also commit to nonvolatile storage |
| wr_req | input | 1 | Write request, held until accepted |
| wr_addr | input | ADDR_W | Write location |
| wr_data | input | DATA_W | Write value |
| wr_ready | output | 1 | A write request is accepted at the clock edge that ends this cycle |
| rd_req | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read location |
| rd_valid | output | 1 | `rd_data` holds the answer to the previous cycle's read |
| rd_data | output | DATA_W | Read value |
| busy | output | 1 | A nonvolatile write is in progress |
| loading | output | 1 | A refill from nonvolatile storage is in progress |

## Verification
The interesting cycles are the ones where two functions act on the same clock edge. A read and a write to the same address at once must return the old value. A power-on strobe can land on a pending write, or inside the busy window of a nonvolatile commit. The bench provokes each of these cases on purpose and then runs a long random mix, in which strobes, reads and writes of both kinds overlap freely. On every clock, a behavioural reference model decides whether the write should be accepted, what the busy and loading outputs should be, and which value a read must return. The bench compares the design against that model.

// File: rtl/snv_pkg.sv
package snv_pkg;

    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_IDLE   = 2'd1,
        ST_NVWAIT = 2'd2
    } snv_state_e;

endpackage

// File: rtl/snv_nv_array.sv
module snv_nv_array #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int WR_DELAY = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = $clog2(WR_DELAY + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } nv_reg_t;

    nv_reg_t           r_d, r_q;
    logic [DATA_W-1:0] cell_d [DEPTH];
    logic [DATA_W-1:0] cell_q [DEPTH];

    always_comb begin
        r_d    = r_q;
        cell_d = cell_q;
        if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - 1'b1;
            if (r_q.cnt == CNT_W'(1)) begin
                cell_d[r_q.addr] = r_q.data;
            end
        end
        if (wr_req && r_q.cnt == '0) begin
            r_d.cnt  = CNT_W'(WR_DELAY);
            r_d.addr = wr_addr;
            r_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                cell_q[i] <= '0;
            end
        end else begin
            r_q    <= r_d;
            cell_q <= cell_d;
        end
    end

    assign busy    = (r_q.cnt != '0);
    assign rd_data = cell_q[rd_addr];

    // R2: the controller never issues a commit while one is running
    a_r2_req_only_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !busy);

    // R2: a commit keeps the array busy on the following cycle
    a_r2_busy_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> busy);

endmodule

// File: rtl/snv_shadow_ram.sv
module snv_shadow_ram #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/snv_seq.sv
module snv_seq
    import snv_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_strobe,
    input  logic              wr_req,
    input  logic              shadow_en,
    input  logic              nv_busy,
    output logic              accept,
    output logic              nv_wr_req,
    output logic              load_we,
    output logic [ADDR_W-1:0] load_addr,
    output logic              wr_ready,
    output logic              busy,
    output logic              loading
);
    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    typedef struct packed {
        snv_state_e        st;
        logic [ADDR_W-1:0] idx;
        logic              pend;
    } seq_reg_t;

    seq_reg_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        wr_ready  = (s_q.st == ST_IDLE) && !por_strobe;
        accept    = wr_req && wr_ready;
        nv_wr_req = accept && !shadow_en;
        load_we   = (s_q.st == ST_LOAD) && !por_strobe;
        load_addr = s_q.idx;

        unique case (s_q.st)
            ST_LOAD: begin
                if (por_strobe) begin
                    s_d.idx = '0;
                end else if (s_q.idx == LAST) begin
                    s_d.st  = ST_IDLE;
                    s_d.idx = '0;
                end else begin
                    s_d.idx = s_q.idx + 1'b1;
                end
            end
            ST_IDLE: begin
                if (por_strobe) begin
                    s_d.st  = ST_LOAD;
                    s_d.idx = '0;
                end else if (nv_wr_req) begin
                    s_d.st = ST_NVWAIT;
                end
            end
            ST_NVWAIT: begin
                if (por_strobe) begin
                    s_d.pend = 1'b1;
                end
                if (!nv_busy) begin
                    s_d.st   = (s_q.pend || por_strobe) ? ST_LOAD : ST_IDLE;
                    s_d.idx  = '0;
                    s_d.pend = 1'b0;
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= ST_LOAD;
            s_q.idx  <= '0;
            s_q.pend <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = (s_q.st == ST_NVWAIT);
    assign loading = (s_q.st == ST_LOAD);

    // R3: no nonvolatile commit is requested in volatile-only mode
    a_r3_shadow_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        nv_wr_req |-> !shadow_en);

    // R8: a deferred strobe exists only while a commit is outstanding
    a_r8_defer_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pend |-> (s_q.st == ST_NVWAIT));

    // R2: the wait state is left only once the array has gone idle
    a_r2_wait_tracks_array: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && nv_busy) |=> busy);

endmodule

// File: rtl/snv_ctrl.sv
module snv_ctrl #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int WR_DELAY = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_strobe,
    input  logic              shadow_en,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              loading
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } rd_reg_t;

    logic              accept, nv_wr_req, nv_busy, load_we;
    logic [ADDR_W-1:0] load_addr;
    logic [DATA_W-1:0] nv_rd_data, sh_rd_data;
    logic              sh_we;
    logic [ADDR_W-1:0] sh_waddr;
    logic [DATA_W-1:0] sh_wdata;
    rd_reg_t           rd_d, rd_q;

    snv_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_strobe (por_strobe),
        .wr_req     (wr_req),
        .shadow_en  (shadow_en),
        .nv_busy    (nv_busy),
        .accept     (accept),
        .nv_wr_req  (nv_wr_req),
        .load_we    (load_we),
        .load_addr  (load_addr),
        .wr_ready   (wr_ready),
        .busy       (busy),
        .loading    (loading)
    );

    snv_nv_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_DELAY(WR_DELAY)) u_nv (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (nv_wr_req),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (load_addr),
        .rd_data (nv_rd_data),
        .busy    (nv_busy)
    );

    always_comb begin
        sh_we    = accept || load_we;
        sh_waddr = load_we ? load_addr : wr_addr;
        sh_wdata = load_we ? nv_rd_data : wr_data;
    end

    snv_shadow_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (sh_we),
        .waddr (sh_waddr),
        .wdata (sh_wdata),
        .raddr (rd_addr),
        .rdata (sh_rd_data)
    );

    always_comb begin
        rd_d     = rd_q;
        rd_d.vld = rd_req && !loading;
        if (rd_req && !loading) begin
            rd_d.data = sh_rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid = rd_q.vld;
    assign rd_data  = rd_q.data;

    // R2: a running commit stalls writes
    a_r2_busy_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_ready);

    // R1: no read is answered for a request made during the refill
    a_r1_no_read_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        loading |=> !rd_valid);

    // R9: a strobe blocks a write in the same cycle
    a_r9_por_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        por_strobe |-> !wr_ready);

    // R1: refill and commit never overlap
    a_r1_load_excludes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(loading && busy));

endmodule

// File: tb/snv_ctrl_test.sv
module snv_ctrl_test;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = 8;
    localparam int WR_DELAY = 5;
    localparam int DEPTH    = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              por_strobe = 1'b0;
    logic              shadow_en = 1'b0;
    logic              wr_req = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_req = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              wr_ready, rd_valid, busy, loading;
    logic [DATA_W-1:0] rd_data;

    always #2 clk = ~clk;

    snv_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_DELAY(WR_DELAY)) uut (
        .clk(clk), .rst_n(rst_n), .por_strobe(por_strobe), .shadow_en(shadow_en),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .busy(busy), .loading(loading)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    int    n_cycles = 0;
    string cur_req  = "R1";

    // reference model state
    logic [DATA_W-1:0] m_sh [DEPTH];
    logic [DATA_W-1:0] m_nv [DEPTH];
    int                m_load, m_wait, m_pend, m_cnt, m_pa;
    logic [DATA_W-1:0] m_pd, m_rd;
    logic              m_rv;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                m_sh[i] = '0;
                m_nv[i] = '0;
            end
            m_load = 0; m_wait = 0; m_pend = 0; m_cnt = 0; m_pa = 0;
            m_pd = '0; m_rd = '0; m_rv = 1'b0;
        end else begin
            int old_cnt, old_load, old_wait;
            logic idle, acc;
            old_cnt  = m_cnt;
            old_load = m_load;
            old_wait = m_wait;
            idle     = (old_load < 0) && (old_wait == 0);
            acc      = wr_req && idle && !por_strobe;
            m_rv     = rd_req && (old_load < 0);
            if (rd_req && old_load < 0) m_rd = m_sh[rd_addr];
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) m_nv[m_pa] = m_pd;
            end
            if (acc && !shadow_en) begin
                m_cnt = WR_DELAY; m_pa = int'(wr_addr); m_pd = wr_data;
            end
            if (old_load >= 0) begin
                if (por_strobe) m_load = 0;
                else begin
                    m_sh[old_load] = m_nv[old_load];
                    m_load = (old_load == DEPTH - 1) ? -1 : old_load + 1;
                end
            end else if (old_wait == 0) begin
                if (por_strobe) m_load = 0;
                else if (acc && !shadow_en) m_wait = 1;
            end else begin
                if (por_strobe) m_pend = 1;
                if (old_cnt == 0) begin
                    m_wait = 0;
                    if (m_pend != 0) m_load = 0;
                    m_pend = 0;
                end
            end
            if (acc) m_sh[wr_addr] = wr_data;
        end
    end

    task automatic chk(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d",
                     cur_req, what, act, exp, n_cycles);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("wr_ready", int'(wr_ready),
                int'((m_load < 0) && (m_wait == 0) && !por_strobe));
            chk("busy", int'(busy), m_wait);
            chk("loading", int'(loading), int'(m_load >= 0));
            chk("rd_valid", int'(rd_valid), int'(m_rv));
            if (m_rv) chk("rd_data", int'(rd_data), int'(m_rd));
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        n_cycles++;
        if (n_cycles == 150000) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", n_cycles);
            summary();
        end
    end

    task automatic cyc(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_write(int a, int d, logic sh);
        logic ok;
        wr_req = 1'b1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d); shadow_en = sh;
        do begin
            @(negedge clk);
            ok = wr_ready;
            cyc();
        end while (!ok);
        wr_req = 1'b0;
    endtask

    task automatic do_read(int a);
        rd_req = 1'b1; rd_addr = ADDR_W'(a);
        cyc();
        rd_req = 1'b0;
    endtask

    task automatic wait_quiet();
        while (loading || busy) cyc();
        cyc();
    endtask

    initial begin
        // R1: reset state and refill window
        cur_req = "R1";
        cyc(3);
        rst_n = 1'b1;
        rd_req = 1'b1; rd_addr = 4'd2;
        cyc(DEPTH + 2);
        rd_req = 1'b0;
        wait_quiet();

        // R2 R7 R5: committed writes, read right after and during busy
        cur_req = "R2";
        do_write(1, 8'h11, 1'b0);
        cur_req = "R7";
        do_read(1);
        cur_req = "R5";
        do_read(1);
        do_read(0);
        wait_quiet();
        cur_req = "R2";
        do_write(2, 8'h22, 1'b0);
        do_write(3, 8'h33, 1'b0);
        wait_quiet();

        // R3: back-to-back volatile writes
        cur_req = "R3";
        for (int i = 0; i < 6; i++) do_write(i, 8'hC0 + i, 1'b1);
        for (int i = 0; i < 6; i++) do_read(i);
        cyc();

        // R4: read and write to same address in the same cycle
        cur_req = "R4";
        rd_req = 1'b1; rd_addr = 4'd4;
        do_write(4, 8'h5A, 1'b1);
        rd_req = 1'b0;
        do_read(4);
        cyc();

        // R6: power cycle discards volatile writes
        cur_req = "R6";
        por_strobe = 1'b1; cyc(); por_strobe = 1'b0;
        wait_quiet();
        for (int i = 0; i < DEPTH; i++) do_read(i);
        cyc();

        // R8: strobe during commit is deferred
        cur_req = "R8";
        do_write(7, 8'hA5, 1'b0);
        cyc(2);
        por_strobe = 1'b1; cyc(); por_strobe = 1'b0;
        wait_quiet();
        do_read(7);
        cyc();

        // R9: strobe with a write request in the same cycle
        cur_req = "R9";
        por_strobe = 1'b1; wr_req = 1'b1; wr_addr = 4'd9; wr_data = 8'h99; shadow_en = 1'b1;
        cyc();
        por_strobe = 1'b0;
        do_write(9, 8'h99, 1'b1);
        do_read(9);

        // R1: strobe inside a refill restarts it
        cur_req = "R1";
        por_strobe = 1'b1; cyc(); por_strobe = 1'b0;
        cyc(5);
        por_strobe = 1'b1; cyc(); por_strobe = 1'b0;
        wait_quiet();

        // random mix of everything
        cur_req = "R4";
        for (int i = 0; i < 3000; i++) begin
            por_strobe = (($urandom % 97) == 0);
            wr_req     = ($urandom % 3) == 0;
            wr_addr    = ADDR_W'($urandom);
            wr_data    = DATA_W'($urandom);
            shadow_en  = ($urandom % 2) == 0;
            rd_req     = ($urandom % 2) == 0;
            rd_addr    = ($urandom % 4 == 0) ? wr_addr : ADDR_W'($urandom);
            cyc();
        end
        por_strobe = 1'b0; wr_req = 1'b0; rd_req = 1'b0;
        wait_quiet();
        cur_req = "R6";
        por_strobe = 1'b1; cyc(); por_strobe = 1'b0;
        wait_quiet();
        for (int i = 0; i < DEPTH; i++) do_read(i);
        cyc(2);
        summary();
    end

endmodule